// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 56-bit physical address. It walks a radix page-table tree in memory that is three levels deep, and it does this for one request at a time. The caller supplies the virtual address together with a translation-base word. The low 44 bits of that word give the page number of the top-level table. The walker then fetches one 64-bit table entry per level over a plain request/response memory port. At each level it uses a 9-bit slice of the virtual page number to pick the entry within the current 4 KiB table page.

A walk ends in one of two ways:
- A physical address built from the bottom-level entry's page number and the untouched 12-bit page offset, together with that entry's permission flags.
- A fault, when an entry is not valid or has the wrong shape for its level.

Large pages are not supported. Any leaf above the bottom level is therefore treated as a fault. The result comes out as a one-cycle completion pulse. The walker accepts a new request only while it is idle.

Top module: `tbl_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` and `mem_req_valid` are 0. `req_ready` is 1 only while no walk is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R2: The first fetch address is {root_base[43:0], vaddr[38:30], 3'b000}. Each later fetch is {next page number, index, 3'b000}. The index is vaddr[29:21] at the middle level and vaddr[20:12] at the bottom level. Every fetch address is 8-byte aligned.
- R3: Bits 63:39 of the virtual address have no effect on any fetch address or on the result.
- R4: At the top and middle levels, an entry with bit 0 (valid) = 1 and bits 3:1 (read, write, execute) all 0 is a pointer. Its bits 53:10 become the page number of the next table.
- R5: An entry with bit 0 = 0 at any level ends the walk with a fault. No further fetch is issued.
- R6: At the top or middle level, a valid entry with any of bits 3:1 set ends the walk with a fault.
- R7: At the bottom level, a valid entry with bits 3:1 all 0 ends the walk with a fault.
- R8: On success, `done_paddr` is {entry[53:10], vaddr[11:0]} and `done_flags` is entry[4:0] (bit 0 valid, 1 read, 2 write, 3 execute, 4 user). On a fault, `done_fault` is 1 and `done_paddr` and `done_flags` are 0.
- R9: `done` is high for exactly one cycle, in the cycle after the last entry is consumed. The walker is ready again in the cycle after that.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address are held stable. A response is consumed only after the request has been accepted. At most one fetch is outstanding, and no fetch is issued while idle.
- R11: `req_valid` is ignored while a walk is in progress, whatever the address. The result returned is the one for the address that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| root_base | input | 64 | Translation-base word; bits 43:0 are the top-level table page number |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch request |
| mem_req_addr | output | 56 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Fetched entry is present |
| mem_rsp_data | input | 64 | Fetched 64-bit table entry |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a page fault |
| done_paddr | output | 56 | Translated physical address |
| done_flags | output | 5 | Leaf permission flags |

## Verification
The bench accepts each fetch on the edge after it appears and returns each entry one cycle later. Under that memory, timing counts from the negative edge on which the request is driven:
- a full walk raises `done` 7 cycles later;
- a fault on the top-level entry raises it after 3 cycles;
- a fault on the middle-level entry raises it after 5 cycles.

Every added cycle of withheld `mem_req_ready` or of response delay lengthens the walk by exactly one cycle per level. The stalled scenario therefore expects 19 cycles.

Each task counts negative edges from the request until `done`, and compares that count with the expected latency. The ports are sampled only on negative edges. The task also checks the logged fetch addresses, and checks on the following negative edge that the pulse has dropped and that `req_ready` is back.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int WK_XLEN    = 64;
  localparam int WK_PTE_W   = 64;
  localparam int WK_IDX_W   = 9;
  localparam int WK_OFF_W   = 12;
  localparam int WK_PPN_W   = 44;
  localparam int WK_PPN_LSB = 10;
  localparam int WK_FLAG_W  = 5;
  localparam int WK_LEVELS  = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L0_REQ,
    ST_L0_WAIT,
    ST_DONE
  } walk_state_t;

  typedef enum logic [1:0] {
    PTE_NEXT,
    PTE_LEAF,
    PTE_BAD
  } pte_kind_t;

  typedef logic [1:0] level_t;
endpackage

// File: rtl/walk_vpn_sel.sv
module walk_vpn_sel
  import walk_pkg::*;
#(
  parameter int IDX_W  = WK_IDX_W,
  parameter int OFF_W  = WK_OFF_W,
  parameter int PPN_W  = WK_PPN_W,
  parameter int LEVELS = WK_LEVELS
) (
  input  logic [LEVELS*IDX_W-1:0] vpn,
  input  level_t                  level,
  input  logic [PPN_W-1:0]        ppn,
  output logic [PPN_W+OFF_W-1:0]  fetch_addr
);
  localparam int ENT_B = OFF_W - IDX_W;
  localparam int SLOTS = 4;

  logic [IDX_W-1:0] idx_arr [SLOTS];
  logic [IDX_W-1:0] idx_sel;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slice
    if (g < LEVELS) begin : g_used
      assign idx_arr[g] = vpn[g*IDX_W +: IDX_W];
    end else begin : g_pad
      assign idx_arr[g] = '0;
    end
  end

  always_comb begin
    idx_sel    = idx_arr[level];
    fetch_addr = {ppn, idx_sel, {ENT_B{1'b0}}};
  end
endmodule

// File: rtl/walk_pte_eval.sv
module walk_pte_eval
  import walk_pkg::*;
#(
  parameter int PTE_W   = WK_PTE_W,
  parameter int PPN_W   = WK_PPN_W,
  parameter int PPN_LSB = WK_PPN_LSB
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic                 at_bottom,
  output pte_kind_t            kind,
  output logic [PPN_W-1:0]     next_ppn,
  output logic [WK_FLAG_W-1:0] flags
);
  logic ent_valid;
  logic ent_perm;
  logic unused_pte_bits;

  assign ent_valid       = pte[0];
  assign ent_perm        = |pte[3:1];
  assign next_ppn        = pte[PPN_LSB +: PPN_W];
  assign flags           = pte[WK_FLAG_W-1:0];
  assign unused_pte_bits = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:WK_FLAG_W]};

  always_comb begin
    if (!ent_valid) begin
      kind = PTE_BAD;
    end else if (at_bottom) begin
      kind = ent_perm ? PTE_LEAF : PTE_BAD;
    end else begin
      kind = ent_perm ? PTE_BAD : PTE_NEXT;
    end
  end
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import walk_pkg::*;
#(
  parameter int XLEN    = WK_XLEN,
  parameter int PTE_W   = WK_PTE_W,
  parameter int IDX_W   = WK_IDX_W,
  parameter int OFF_W   = WK_OFF_W,
  parameter int PPN_W   = WK_PPN_W,
  parameter int PPN_LSB = WK_PPN_LSB,
  parameter int PA_W    = WK_PPN_W + WK_OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [XLEN-1:0]      req_vaddr,
  input  logic [XLEN-1:0]      root_base,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [PA_W-1:0]      mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [PTE_W-1:0]     mem_rsp_data,
  output logic                 done,
  output logic                 done_fault,
  output logic [PA_W-1:0]      done_paddr,
  output logic [WK_FLAG_W-1:0] done_flags
);
  localparam int VA_W = OFF_W + WK_LEVELS*IDX_W;

  walk_state_t          st_q, st_d;
  logic [VA_W-1:0]      va_q;
  logic [PPN_W-1:0]     ppn_q, ppn_d;
  logic [PA_W-1:0]      pa_q, pa_d;
  logic [WK_FLAG_W-1:0] fl_q, fl_d;
  logic                 flt_q, flt_d;

  level_t               lvl;
  logic                 in_wait;
  logic                 at_bottom;
  logic                 accept;
  logic                 take;
  logic                 va_en, ppn_en, res_en;
  pte_kind_t            kind;
  logic [PPN_W-1:0]     ent_ppn;
  logic [WK_FLAG_W-1:0] ent_flags;
  logic                 unused_hi_bits;

  assign unused_hi_bits = ^{req_vaddr[XLEN-1:VA_W], root_base[XLEN-1:PPN_W]};

  walk_vpn_sel #(
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .PPN_W (PPN_W),
    .LEVELS(WK_LEVELS)
  ) u_sel (
    .vpn       (va_q[VA_W-1:OFF_W]),
    .level     (lvl),
    .ppn       (ppn_q),
    .fetch_addr(mem_req_addr)
  );

  walk_pte_eval #(
    .PTE_W  (PTE_W),
    .PPN_W  (PPN_W),
    .PPN_LSB(PPN_LSB)
  ) u_eval (
    .pte      (mem_rsp_data),
    .at_bottom(at_bottom),
    .kind     (kind),
    .next_ppn (ent_ppn),
    .flags    (ent_flags)
  );

  always_comb begin
    unique case (st_q)
      ST_L2_REQ, ST_L2_WAIT: lvl = 2'd2;
      ST_L1_REQ, ST_L1_WAIT: lvl = 2'd1;
      default:               lvl = 2'd0;
    endcase
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_L2_REQ) || (st_q == ST_L1_REQ) || (st_q == ST_L0_REQ);
  assign in_wait       = (st_q == ST_L2_WAIT) || (st_q == ST_L1_WAIT) || (st_q == ST_L0_WAIT);
  assign at_bottom     = (st_q == ST_L0_WAIT);
  assign accept        = req_valid && req_ready;
  assign take          = in_wait && mem_rsp_valid;
  assign done          = (st_q == ST_DONE);
  assign done_fault    = flt_q;
  assign done_paddr    = pa_q;
  assign done_flags    = fl_q;

  // Next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_valid) st_d = ST_L2_REQ;
      ST_L2_REQ:  if (mem_req_ready) st_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid) st_d = (kind == PTE_NEXT) ? ST_L1_REQ : ST_DONE;
      ST_L1_REQ:  if (mem_req_ready) st_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid) st_d = (kind == PTE_NEXT) ? ST_L0_REQ : ST_DONE;
      ST_L0_REQ:  if (mem_req_ready) st_d = ST_L0_WAIT;
      ST_L0_WAIT: if (mem_rsp_valid) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // Datapath enables and next values
  always_comb begin
    va_en  = accept;
    ppn_en = accept || (take && (kind == PTE_NEXT));
    res_en = take && (kind != PTE_NEXT);
    ppn_d  = accept ? root_base[PPN_W-1:0] : ent_ppn;
    flt_d  = (kind == PTE_BAD);
    pa_d   = flt_d ? '0 : {ent_ppn, va_q[OFF_W-1:0]};
    fl_d   = flt_d ? '0 : ent_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q <= '0;
    end else if (va_en) begin
      va_q <= req_vaddr[VA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppn_q <= '0;
    end else if (ppn_en) begin
      ppn_q <= ppn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      fl_q  <= '0;
      flt_q <= 1'b0;
    end else if (res_en) begin
      pa_q  <= pa_d;
      fl_q  <= fl_d;
      flt_q <= flt_d;
    end
  end
endmodule

// File: rtl/walk_checks.sv
module walk_checks
  import walk_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic [WK_XLEN-1:0]              req_vaddr,
  input logic [WK_XLEN-1:0]              root_base,
  input logic                            mem_req_valid,
  input logic                            mem_req_ready,
  input logic [WK_PPN_W+WK_OFF_W-1:0]    mem_req_addr,
  input logic                            done,
  input logic                            done_fault,
  input logic [WK_PPN_W+WK_OFF_W-1:0]    done_paddr,
  input logic [WK_FLAG_W-1:0]            done_flags
);
  localparam int TOP_LSB = WK_OFF_W + 2*WK_IDX_W;

  logic [WK_XLEN-1:0]  vq;
  logic [WK_PPN_W-1:0] rq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= '0;
      rq <= '0;
    end else if (req_valid && req_ready) begin
      vq <= req_vaddr;
      rq <= root_base[WK_PPN_W-1:0];
    end
  end

  p_root_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready) |->
      mem_req_valid && (mem_req_addr == {rq, vq[TOP_LSB +: WK_IDX_W], 3'b000}));

  p_fetch_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> ((done_paddr == '0) && (done_flags == '0)));

  p_leaf_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fault) |-> (done_flags[0] && (done_flags[3:1] != 3'b000)));

  p_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fault) |-> (done_paddr[WK_OFF_W-1:0] == vq[WK_OFF_W-1:0]));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && req_ready));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> !req_ready);
endmodule

bind tbl_walker walk_checks u_chk (.*);

// File: tb/sim_tbl_walker.sv
`timescale 1ns/1ps
module sim_tbl_walker;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [63:0] root_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic        done_fault;
  logic [55:0] done_paddr;
  logic [4:0]  done_flags;

  int n_chk;
  int n_fail;

  logic [63:0] pmem [logic [55:0]];
  logic [55:0] flog [8];
  int          fcnt;
  int          ready_gap;
  int          rsp_delay;

  tbl_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_fault(done_fault), .done_paddr(done_paddr), .done_flags(done_flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [55:0] ea(input logic [43:0] ppn, input logic [8:0] idx);
    return {ppn, idx, 3'b000};
  endfunction

  function automatic logic [63:0] mk_ent(input logic [43:0] ppn, input logic [4:0] fl);
    return {10'b0, ppn, 5'b0, fl};
  endfunction

  function automatic logic [63:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                       input logic [8:0] c, input logic [11:0] off);
    return {25'b0, a, b, c, off};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Memory model: accepts each fetch, answers rsp_delay cycles later
  initial begin
    logic        pend;
    logic [55:0] paddr;
    int          wcnt;
    int          gcnt;
    pend = 1'b0;
    wcnt = 0;
    gcnt = 0;
    paddr = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    mem_req_ready = 1'b1;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = pmem.exists(paddr) ? pmem[paddr] : 64'h0;
          pend = 1'b0;
        end else begin
          wcnt--;
        end
      end else if (mem_req_valid) begin
        if (gcnt < ready_gap) begin
          mem_req_ready = 1'b0;
          gcnt++;
        end else begin
          mem_req_ready = 1'b1;
          gcnt = 0;
          pend = 1'b1;
          paddr = mem_req_addr;
          wcnt = rsp_delay;
          if (fcnt < 8) flog[fcnt] = mem_req_addr;
          fcnt++;
        end
      end
    end
  end

  task automatic do_walk(input logic [63:0] va, input bit exp_flt, input logic [55:0] exp_pa,
                         input logic [4:0] exp_fl, input int exp_lat, input int exp_nf,
                         input logic [55:0] a0, input logic [55:0] a1, input logic [55:0] a2,
                         input bit jam, input string tag);
    int lat;
    logic [55:0] ea_exp [3];
    ea_exp[0] = a0;
    ea_exp[1] = a1;
    ea_exp[2] = a2;
    fcnt = 0;
    lat = 0;
    req_vaddr = va;
    req_valid = 1'b1;
    while (1) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        chk(req_ready == 1'b0, {tag, " R1 busy"}, 64'(req_ready), 64'd0);
        if (jam) req_vaddr = mkva(9'd5, 9'd0, 9'd0, 12'h0); // R11 stray request
        else req_valid = 1'b0;
      end
      if (done || lat > 200) break;
    end
    req_valid = 1'b0;
    chk(lat == exp_lat, {tag, " R9 latency"}, 64'(lat), 64'(exp_lat));
    chk(done_fault == exp_flt, {tag, " R5/R6/R7 fault"}, 64'(done_fault), 64'(exp_flt));
    chk(done_paddr == exp_pa, {tag, " R8 paddr"}, 64'(done_paddr), 64'(exp_pa));
    chk(done_flags == exp_fl, {tag, " R8 flags"}, 64'(done_flags), 64'(exp_fl));
    chk(fcnt == exp_nf, {tag, " R10 fetch count"}, 64'(fcnt), 64'(exp_nf));
    for (int i = 0; i < exp_nf && i < 3; i++)
      chk(flog[i] == ea_exp[i], {tag, " R2 fetch addr"}, 64'(flog[i]), 64'(ea_exp[i]));
    @(negedge clk);
    chk(!done && req_ready && !mem_req_valid, {tag, " R9 back to idle"},
        {61'b0, done, req_ready, mem_req_valid}, 64'b010);
  endtask

  localparam logic [43:0] RT = 44'h100;
  localparam logic [43:0] MD = 44'h200;
  localparam logic [43:0] BT = 44'h300;
  localparam logic [43:0] LP = 44'hABCDE;

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 reset fetch", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_full;   // R4 R8
    do_walk(mkva(9'd1, 9'd2, 9'd3, 12'hABC), 1'b0, {LP, 12'hABC}, 5'h1B, 7, 3,
            ea(RT, 9'd1), ea(MD, 9'd2), ea(BT, 9'd3), 1'b0, "full");
  endtask

  task automatic t_upper;  // R3
    do_walk(64'hFFFF_FF80_0000_0000 | mkva(9'd1, 9'd2, 9'd3, 12'h123), 1'b0, {LP, 12'h123}, 5'h1B, 7, 3,
            ea(RT, 9'd1), ea(MD, 9'd2), ea(BT, 9'd3), 1'b0, "R3 upper");
  endtask

  task automatic t_invalid; // R5
    do_walk(mkva(9'd5, 9'd0, 9'd0, 12'h0), 1'b1, '0, '0, 3, 1,
            ea(RT, 9'd5), '0, '0, 1'b0, "R5 root invalid");
    do_walk(mkva(9'd1, 9'd2, 9'd4, 12'h0), 1'b1, '0, '0, 7, 3,
            ea(RT, 9'd1), ea(MD, 9'd2), ea(BT, 9'd4), 1'b0, "R5 bottom invalid");
  endtask

  task automatic t_large;   // R6
    do_walk(mkva(9'd7, 9'd0, 9'd0, 12'h0), 1'b1, '0, '0, 3, 1,
            ea(RT, 9'd7), '0, '0, 1'b0, "R6 root leaf");
    do_walk(mkva(9'd1, 9'd6, 9'd0, 12'h0), 1'b1, '0, '0, 5, 2,
            ea(RT, 9'd1), ea(MD, 9'd6), '0, 1'b0, "R6 middle leaf");
  endtask

  task automatic t_bottom_ptr; // R7
    do_walk(mkva(9'd1, 9'd2, 9'd9, 12'h0), 1'b1, '0, '0, 7, 3,
            ea(RT, 9'd1), ea(MD, 9'd2), ea(BT, 9'd9), 1'b0, "R7 bottom pointer");
  endtask

  task automatic t_stall;   // R10
    ready_gap = 2;
    rsp_delay = 2;
    do_walk(mkva(9'd1, 9'd2, 9'd8, 12'h00F), 1'b0, {44'h12345, 12'h00F}, 5'h07, 19, 3,
            ea(RT, 9'd1), ea(MD, 9'd2), ea(BT, 9'd8), 1'b0, "R10 stall");
    ready_gap = 0;
    rsp_delay = 0;
  endtask

  task automatic t_busy;    // R11
    do_walk(mkva(9'd1, 9'd2, 9'd3, 12'h777), 1'b0, {LP, 12'h777}, 5'h1B, 7, 3,
            ea(RT, 9'd1), ea(MD, 9'd2), ea(BT, 9'd3), 1'b1, "R11 busy ignore");
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    fcnt = 0;
    ready_gap = 0;
    rsp_delay = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    root_base = {20'hFFFFF, RT};
    pmem[ea(RT, 9'd1)] = mk_ent(MD, 5'h01);
    pmem[ea(RT, 9'd7)] = mk_ent(44'h999, 5'h09);
    pmem[ea(MD, 9'd2)] = mk_ent(BT, 5'h01);
    pmem[ea(MD, 9'd6)] = mk_ent(44'h888, 5'h03);
    pmem[ea(BT, 9'd3)] = mk_ent(LP, 5'h1B);
    pmem[ea(BT, 9'd8)] = mk_ent(44'h12345, 5'h07);
    pmem[ea(BT, 9'd9)] = mk_ent(44'h777, 5'h01);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_upper();
    t_invalid();
    t_large();
    t_bottom_ptr();
    t_stall();
    t_busy();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule